// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the processor-facing register port of an eight-level interrupt controller. The processor reaches it with a chip select, a write strobe, a read strobe, one address bit and an 8-bit data bus that is split into an input half and an output half. Every input is sampled synchronously: each clock cycle in which select and a strobe are both high counts as one access.

After reset the port waits for a start byte. That byte opens an initialisation sequence of two to four bytes, and the bits of the start byte decide which of the optional bytes follow. Once the sequence is complete, address-1 writes load the mask register. Address-0 writes are split into two kinds of operation word. One kind gives end-of-interrupt and rotation commands. The other gives read-select, special-mask and poll controls.

The stored configuration and the one-cycle command strobes go to the resolver and in-service logic next to this block. Those blocks provide the request, in-service and poll bytes that this port returns on reads.

Top module: `icu_cmd_port`

## Requirements
- R1: After reset, init_done, mask, dout, all configuration outputs, smm, rot_aeoi, poll_pending, isr_clr and cmd_stb are 0.
- R2: A write with addr=0 and din[4]=1 starts initialisation, in any state. It stores level_trig=din[3], single_mode=din[1] and the need-fourth flag=din[0]. It clears mask, casc_cfg, the fourth-byte modes, smm, rot_aeoi and poll_pending, and selects request-register reads. It pulses isr_clr for exactly the next cycle.
- R3: The next addr=1 write sets vec_base to din[7:3]. A third byte is expected only if single_mode=0. A fourth byte is expected only if the need-fourth flag is 1. init_done rises after the last expected byte.
- R4: The third byte is stored whole in casc_cfg. A slave takes its ID from casc_cfg[2:0].
- R5: The fourth byte sets auto_eoi=din[1], buf_master=din[2], buf_en=din[3] and sfnm=din[4].
- R6: Once initialised, an addr=1 write loads mask with din. An addr=1 read returns mask. mask changes only on such a write or on a start byte.
- R7: Once initialised, an addr=0 write with din[4:3]=00 raises cmd_stb for one cycle. cmd_rot, cmd_sel and cmd_eoi take din[7:5], and cmd_lvl takes din[2:0].
- R8: In that word, din[7:5]=100 sets rot_aeoi and din[7:5]=000 clears it. Every other pattern leaves it unchanged.
- R9: An addr=0 write with din[4:3]=01 and din[6]=1 sets smm to din[5]. With din[6]=0, smm is unchanged.
- R10: In that word, din[1]=1 selects which register an addr=0 read returns: the in-service byte if din[0]=1, the request byte if din[0]=0. With din[1]=0 the selection is kept.
- R11: In that word, din[2]=1 sets poll_pending. The next read clears it. An addr=0 read while poll_pending is set returns poll_in.
- R12: Read data shows on dout the cycle after the read strobe and holds until the next read.
- R13: Before initialisation completes, addr=1 writes and addr=0 writes with din[4]=0 have no effect, and cmd_stb stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 1 | Register address bit |
| din | input | DW | Write data |
| dout | output | DW | Registered read data |
| irr_in | input | DW | Request register from the resolver |
| isr_in | input | DW | In-service register from the resolver |
| poll_in | input | DW | Poll result byte from the resolver |
| init_done | output | 1 | Initialisation sequence complete |
| level_trig | output | 1 | Level-sensitive request mode |
| single_mode | output | 1 | Single controller, no third byte |
| vec_base | output | DW-LW | Upper vector bits |
| casc_cfg | output | DW | Slave map or slave ID byte |
| auto_eoi | output | 1 | Automatic end of interrupt |
| buf_master | output | 1 | Buffered mode acts as master |
| buf_en | output | 1 | Buffered mode |
| sfnm | output | 1 | Special fully nested mode |
| mask | output | DW | Mask register |
| isr_clr | output | 1 | One-cycle in-service clear |
| cmd_stb | output | 1 | End/rotate command strobe |
| cmd_rot | output | 1 | Command rotate flag |
| cmd_sel | output | 1 | Command uses cmd_lvl |
| cmd_eoi | output | 1 | Command is an end of interrupt |
| cmd_lvl | output | LW | Command level |
| rot_aeoi | output | 1 | Rotate on automatic end of interrupt |
| smm | output | 1 | Special mask mode |
| poll_pending | output | 1 | Next read is a poll |

## Verification
The bench targets the branches of the initialisation sequence: a single-mode start that skips the third byte and a cascade start that skips the fourth. A design with the branch wrong would treat the mask byte as configuration, or would never raise init_done. It also writes operation words while initialisation is still open. A design that decodes them too early would fire cmd_stb or corrupt the mask. The bench also checks that a read-select word with the enable bit clear keeps the current selection, that a poll read is consumed exactly once, and that restarting clears the special-mask and read-select state. A design that mishandles any of these returns the wrong register on later reads.

// File: rtl/icu_cmd_pkg.sv
package icu_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_B2   = 3'd1,
    ST_B3   = 3'd2,
    ST_B4   = 3'd3,
    ST_RUN  = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic level_trig;
    logic single;
    logic need4;
  } cfg1_t;

  typedef struct packed {
    logic sfnm;
    logic buf_en;
    logic buf_master;
    logic auto_eoi;
  } cfg4_t;

  // bit positions decoded by neighbouring logic
  localparam int unsigned B_NEED4  = 0;
  localparam int unsigned B_SINGLE = 1;
  localparam int unsigned B_LEVEL  = 3;
  localparam int unsigned B_START  = 4;
  localparam int unsigned B_KIND   = 3;
  localparam int unsigned B_RIS    = 0;
  localparam int unsigned B_RR     = 1;
  localparam int unsigned B_POLL   = 2;
  localparam int unsigned B_SMV    = 5;
  localparam int unsigned B_SME    = 6;
endpackage

// File: rtl/icu_cmd_seq.sv
module icu_cmd_seq
  import icu_cmd_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned LW = $clog2(DW),
  localparam int unsigned BW = DW - LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic          addr,
  input  logic [DW-1:0] din,
  output logic          start,
  output logic          wr_op0,
  output logic          wr_op1,
  output logic          init_done,
  output logic          isr_clr,
  output cfg1_t         cfg1,
  output logic [BW-1:0] vec_base,
  output logic [DW-1:0] casc_cfg,
  output cfg4_t         cfg4
);
  seq_st_e st;

  assign start  = wr_stb && !addr && din[B_START];
  assign wr_op0 = wr_stb && !addr && !din[B_START] && (st == ST_RUN);
  assign wr_op1 = wr_stb && addr && (st == ST_RUN);
  assign init_done = (st == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cfg1     <= '0;
      vec_base <= '0;
      casc_cfg <= '0;
      cfg4     <= '0;
      isr_clr  <= 1'b0;
    end else begin
      isr_clr <= start;
      if (start) begin
        cfg1.level_trig <= din[B_LEVEL];
        cfg1.single     <= din[B_SINGLE];
        cfg1.need4      <= din[B_NEED4];
        casc_cfg        <= '0;
        cfg4            <= '0;
        st              <= ST_B2;
      end else if (wr_stb && addr) begin
        case (st)
          ST_B2: begin
            vec_base <= din[DW-1:LW];
            if (!cfg1.single)    st <= ST_B3;
            else if (cfg1.need4) st <= ST_B4;
            else                 st <= ST_RUN;
          end
          ST_B3: begin
            casc_cfg <= din;
            st <= cfg1.need4 ? ST_B4 : ST_RUN;
          end
          ST_B4: begin
            cfg4.auto_eoi   <= din[1];
            cfg4.buf_master <= din[2];
            cfg4.buf_en     <= din[3];
            cfg4.sfnm       <= din[4];
            st <= ST_RUN;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/icu_cmd_opdec.sv
module icu_cmd_opdec
  import icu_cmd_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr_op0,
  input  logic          wr_op1,
  input  logic          rd_stb,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] mask,
  output logic          cmd_stb,
  output logic          cmd_rot,
  output logic          cmd_sel,
  output logic          cmd_eoi,
  output logic [LW-1:0] cmd_lvl,
  output logic          rot_aeoi,
  output logic          smm,
  output logic          read_isr,
  output logic          poll_pending
);
  logic is_cmd, is_ctl;
  assign is_cmd = wr_op0 && !din[B_KIND];
  assign is_ctl = wr_op0 && din[B_KIND];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
    end else if (start) begin
      mask <= '0;
    end else if (wr_op1) begin
      mask <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_stb <= 1'b0;
      cmd_rot <= 1'b0;
      cmd_sel <= 1'b0;
      cmd_eoi <= 1'b0;
      cmd_lvl <= '0;
    end else begin
      cmd_stb <= is_cmd;
      if (is_cmd) begin
        cmd_rot <= din[7];
        cmd_sel <= din[6];
        cmd_eoi <= din[5];
        cmd_lvl <= din[LW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      rot_aeoi <= 1'b0;
    end else if (is_cmd && din[6:5] == 2'b00) begin
      rot_aeoi <= din[7];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      smm      <= 1'b0;
      read_isr <= 1'b0;
    end else if (is_ctl) begin
      if (din[B_SME]) smm      <= din[B_SMV];
      if (din[B_RR])  read_isr <= din[B_RIS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      poll_pending <= 1'b0;
    end else if (is_ctl && din[B_POLL]) begin
      poll_pending <= 1'b1;
    end else if (rd_stb) begin
      poll_pending <= 1'b0;
    end
  end
endmodule

// File: rtl/icu_cmd_rdmux.sv
module icu_cmd_rdmux #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_stb,
  input  logic          addr,
  input  logic          poll_pending,
  input  logic          read_isr,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] irr_in,
  input  logic [DW-1:0] isr_in,
  input  logic [DW-1:0] poll_in,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] sel;

  always_comb begin
    if (addr)              sel = mask;
    else if (poll_pending) sel = poll_in;
    else if (read_isr)     sel = isr_in;
    else                   sel = irr_in;
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (rd_stb) dout <= sel;
  end
endmodule

// File: rtl/icu_cmd_port.sv
module icu_cmd_port
  import icu_cmd_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned LW = $clog2(DW),
  localparam int unsigned BW = DW - LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          wr,
  input  logic          rd,
  input  logic          addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic [DW-1:0] irr_in,
  input  logic [DW-1:0] isr_in,
  input  logic [DW-1:0] poll_in,
  output logic          init_done,
  output logic          level_trig,
  output logic          single_mode,
  output logic [BW-1:0] vec_base,
  output logic [DW-1:0] casc_cfg,
  output logic          auto_eoi,
  output logic          buf_master,
  output logic          buf_en,
  output logic          sfnm,
  output logic [DW-1:0] mask,
  output logic          isr_clr,
  output logic          cmd_stb,
  output logic          cmd_rot,
  output logic          cmd_sel,
  output logic          cmd_eoi,
  output logic [LW-1:0] cmd_lvl,
  output logic          rot_aeoi,
  output logic          smm,
  output logic          poll_pending
);
  logic  wr_stb, rd_stb, start, wr_op0, wr_op1, read_isr;
  cfg1_t cfg1;
  cfg4_t cfg4;

  assign wr_stb = cs && wr;
  assign rd_stb = cs && rd;

  icu_cmd_seq #(.DW(DW)) seq_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(addr), .din(din),
    .start(start), .wr_op0(wr_op0), .wr_op1(wr_op1),
    .init_done(init_done), .isr_clr(isr_clr), .cfg1(cfg1),
    .vec_base(vec_base), .casc_cfg(casc_cfg), .cfg4(cfg4)
  );

  icu_cmd_opdec #(.DW(DW)) opdec_i (
    .clk(clk), .rst(rst), .start(start), .wr_op0(wr_op0), .wr_op1(wr_op1),
    .rd_stb(rd_stb), .din(din), .mask(mask), .cmd_stb(cmd_stb),
    .cmd_rot(cmd_rot), .cmd_sel(cmd_sel), .cmd_eoi(cmd_eoi),
    .cmd_lvl(cmd_lvl), .rot_aeoi(rot_aeoi), .smm(smm),
    .read_isr(read_isr), .poll_pending(poll_pending)
  );

  icu_cmd_rdmux #(.DW(DW)) rdmux_i (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .addr(addr),
    .poll_pending(poll_pending), .read_isr(read_isr), .mask(mask),
    .irr_in(irr_in), .isr_in(isr_in), .poll_in(poll_in), .dout(dout)
  );

  assign level_trig  = cfg1.level_trig;
  assign single_mode = cfg1.single;
  assign auto_eoi    = cfg4.auto_eoi;
  assign buf_master  = cfg4.buf_master;
  assign buf_en      = cfg4.buf_en;
  assign sfnm        = cfg4.sfnm;
endmodule

// File: rtl/icu_cmd_port_chk.sv
module icu_cmd_port_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic          wr,
  input logic          rd,
  input logic          addr,
  input logic [1:0]    din_kind,
  input logic [DW-1:0] dout,
  input logic [DW-1:0] mask,
  input logic          isr_clr,
  input logic          cmd_stb,
  input logic          init_done,
  input logic          poll_pending,
  input logic          smm
);
  AST_CLR_FROM_START: assert property (@(posedge clk) disable iff (rst)
    isr_clr |-> $past(cs && wr && !addr && din_kind[1])); // R2
  AST_CLR_EMPTIES_MASK: assert property (@(posedge clk) disable iff (rst)
    isr_clr |-> (mask == '0 && !smm && !init_done)); // R2
  AST_CMD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> $past(cs && wr && !addr && din_kind == 2'b00)); // R7
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_stb, isr_clr})); // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr) |=> $stable(mask)); // R6
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd) |=> $stable(dout)); // R12
  AST_POLL_DROP: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && !wr) |=> !poll_pending); // R11
  AST_NO_CMD_IN_INIT: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !cmd_stb); // R13
endmodule

bind icu_cmd_port icu_cmd_port_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
  .din_kind(din[4:3]), .dout(dout), .mask(mask), .isr_clr(isr_clr),
  .cmd_stb(cmd_stb), .init_done(init_done), .poll_pending(poll_pending),
  .smm(smm)
);

// File: tb/icu_cmd_port_tb_top.sv
`timescale 1ns/1ps
module icu_cmd_port_tb_top;
  localparam int unsigned DW = 8;
  localparam int unsigned LW = $clog2(DW);
  localparam int unsigned BW = DW - LW;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 0, wr = 0, rd = 0, addr = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] irr_in = 8'hA5, isr_in = 8'h3C, poll_in = 8'h83;
  logic [DW-1:0] dout, casc_cfg, mask;
  logic [BW-1:0] vec_base;
  logic [LW-1:0] cmd_lvl;
  logic init_done, level_trig, single_mode, auto_eoi, buf_master, buf_en, sfnm;
  logic isr_clr, cmd_stb, cmd_rot, cmd_sel, cmd_eoi, rot_aeoi, smm, poll_pending;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  icu_cmd_port #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .addr(addr), .din(din),
    .dout(dout), .irr_in(irr_in), .isr_in(isr_in), .poll_in(poll_in),
    .init_done(init_done), .level_trig(level_trig), .single_mode(single_mode),
    .vec_base(vec_base), .casc_cfg(casc_cfg), .auto_eoi(auto_eoi),
    .buf_master(buf_master), .buf_en(buf_en), .sfnm(sfnm), .mask(mask),
    .isr_clr(isr_clr), .cmd_stb(cmd_stb), .cmd_rot(cmd_rot), .cmd_sel(cmd_sel),
    .cmd_eoi(cmd_eoi), .cmd_lvl(cmd_lvl), .rot_aeoi(rot_aeoi), .smm(smm),
    .poll_pending(poll_pending)
  );

  // {req[3:0], is_read, addr, data[7:0], expected[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {4'd2,  1'b0, 1'b0, 8'h1B, 8'h00}, // R2 start: need4, single, level
    {4'd3,  1'b0, 1'b1, 8'h48, 8'h00}, // R3 vector base 9
    {4'd5,  1'b0, 1'b1, 8'h1E, 8'h00}, // R5 fourth byte
    {4'd6,  1'b1, 1'b1, 8'h00, 8'h00}, // R6 mask cleared
    {4'd6,  1'b0, 1'b1, 8'h5A, 8'h00}, // R6 load mask
    {4'd6,  1'b1, 1'b1, 8'h00, 8'h5A}, // R6 read mask
    {4'd10, 1'b1, 1'b0, 8'h00, 8'hA5}, // R10 request byte by default
    {4'd10, 1'b0, 1'b0, 8'h0B, 8'h00}, // R10 select in-service
    {4'd10, 1'b1, 1'b0, 8'h00, 8'h3C}, // R10
    {4'd10, 1'b0, 1'b0, 8'h0A, 8'h00}, // R10 select request
    {4'd10, 1'b1, 1'b0, 8'h00, 8'hA5}, // R10
    {4'd11, 1'b0, 1'b0, 8'h0C, 8'h00}, // R11 poll
    {4'd11, 1'b1, 1'b0, 8'h00, 8'h83}, // R11 poll byte
    {4'd11, 1'b1, 1'b0, 8'h00, 8'hA5}, // R11 consumed once
    {4'd10, 1'b0, 1'b0, 8'h09, 8'h00}  // R10 enable clear: selection kept
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [DW-1:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; din = d;
    @(negedge clk); cs = 0; wr = 0; din = '0;
  endtask

  task automatic do_rd(input logic a);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 init_done", init_done, 0);
    check("R1 mask", mask, 0);
    check("R1 dout", dout, 0);
    check("R1 strobes", {cmd_stb, isr_clr, smm, rot_aeoi, poll_pending}, 0);

    // R13 mask write before any start byte is ignored
    do_wr(1'b1, 8'hFF);
    check("R13 idle mask", mask, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17]) begin
        do_rd(VEC[i][16]);
        check($sformatf("R%0d table %0d", VEC[i][21:18], i), dout, VEC[i][7:0]);
      end else begin
        do_wr(VEC[i][16], VEC[i][15:8]);
      end
    end
    do_rd(1'b0);
    check("R10 kept selection", dout, 8'hA5);

    // R3 R5 configuration from single-mode start
    check("R3 done after three bytes", init_done, 1);
    check("R3 vec_base", vec_base, 5'd9);
    check("R2 cfg1", {level_trig, single_mode}, 2'b11);
    check("R5 cfg4", {sfnm, buf_en, buf_master, auto_eoi}, 4'hF);

    // R12 read data holds
    do_rd(1'b1);
    repeat (3) @(negedge clk);
    check("R12 hold", dout, 8'h5A);

    // R7 specific end for level 6
    do_wr(1'b0, 8'h66);
    check("R7 strobe", cmd_stb, 1);
    check("R7 flags", {cmd_rot, cmd_sel, cmd_eoi, cmd_lvl}, {3'b011, 3'd6});
    @(negedge clk);
    check("R7 one cycle", cmd_stb, 0);

    // R8 rotate on automatic end
    do_wr(1'b0, 8'h80);
    check("R8 set", rot_aeoi, 1);
    do_wr(1'b0, 8'h20);
    check("R8 kept", rot_aeoi, 1);
    do_wr(1'b0, 8'h00);
    check("R8 clear", rot_aeoi, 0);

    // R9 special mask
    do_wr(1'b0, 8'h68);
    check("R9 on", smm, 1);
    do_wr(1'b0, 8'h28);
    check("R9 enable clear keeps", smm, 1);
    do_wr(1'b0, 8'h48);
    check("R9 off", smm, 0);

    // R2 restart clears state: cascade, no fourth byte
    do_wr(1'b0, 8'h0B);
    do_wr(1'b0, 8'h68);
    do_wr(1'b0, 8'h10);
    check("R2 isr_clr", isr_clr, 1);
    check("R2 cleared", {mask, smm, init_done}, 0);
    @(negedge clk);
    check("R2 isr_clr one cycle", isr_clr, 0);
    do_wr(1'b0, 8'h66);
    check("R13 cmd in init", cmd_stb, 0);
    do_wr(1'b1, 8'h70);
    check("R3 waits for third", init_done, 0);
    do_wr(1'b1, 8'h04);
    check("R3 done without fourth", init_done, 1);
    check("R4 casc", casc_cfg, 8'h04);
    check("R3 vec_base", vec_base, 5'd14);
    check("R2 fourth modes cleared", {sfnm, buf_en, buf_master, auto_eoi}, 0);
    check("R2 single bit", single_mode, 0);
    do_rd(1'b0);
    check("R2 read select reset", dout, 8'hA5);
    do_wr(1'b1, 8'h33);
    check("R6 mask after cascade init", mask, 8'h33);

    finish_run();
  end
endmodule